// File: doc/BRIEF.md
# Low-Speed Timekeeping Clock Selector

This block picks the tick that drives a low-speed timekeeping domain. Two single-cycle enable inputs stand for the sources: `rc_tick` from an internal RC oscillator and `xtal_tick` from an external 32 kHz crystal. Both are already synchronous to the system clock `clk`. The internal path is slowed by a fixed pre-divide, set by the parameter `PRE_DIV`. A programmable divide by (P+1) follows it. The external path passes through undivided. A second output copies the selected tick onto a pin enable when the gate bit is set.

A small word-addressed register port holds three registers: control, prescale and output gate. The control register only accepts writes that carry a 16-bit key in the upper half. A failure flag from the crystal monitor can force the internal path without touching the stored select bit, unless bypass is set.

The source choice is a three-state machine with these states:

- `ST_INT`: the internal path is selected.
- `ST_EXT`: the external clock is in use.
- `ST_FALLBACK`: the external clock is selected but failed, so the internal path is used.

The transitions are:

- **go_ext**: from INT to EXT when select is 1 and there is no unbypassed failure.
- **go_fallback**: from INT or EXT to FALLBACK when select is 1, `ext_fail` is 1 and bypass is 0.
- **recover**: from FALLBACK to EXT when the failure clears or bypass is set.
- **go_int**: from any state to INT when select is 0.

The state register updates one cycle after its inputs change. The output tick is registered once more.

Top module: `lsclk_sel`

## Requirements
- R1: A write to the control register (address 0) changes it only when wdata[31:16] equals 16'h16AA. Any other key leaves the register and the selected source unchanged.
- R2: Reading the control register returns the stored fields in fixed positions: bit 0 is select (1 = external), bit 4 is the crystal enable and bit 15 is the fall-back bypass. Every other bit, including [31:16], reads 0.
- R3: With the internal path in use and `rc_tick` high every cycle, `lsclk_tick` is a one-cycle pulse every PRE_DIV*(P+1) cycles. P is prescale register (address 1) bits [4:0].
- R4: With the external path in use, `lsclk_tick` equals `xtal_tick` delayed by one clock, with no division.
- R5: When select is 1, bypass is 0 and `ext_fail` is 1, the internal divided path drives `lsclk_tick`. The stored select bit still reads 1.
- R6: When bypass is 1, `ext_fail` has no effect and the external clock keeps driving `lsclk_tick`.
- R7: A write that changes P restarts both divide counters. The first pulse appears PRE_DIV*(P+1) clock edges after the write edge.
- R8: `pin_tick` equals `lsclk_tick` when gate register (address 2) bit 0 is 1, and it is 0 otherwise.
- R9: After reset all three registers read 0, the internal path is selected and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address (0 control, 1 prescale, 2 gate) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| rc_tick | input | 1 | Internal RC oscillator enable pulse |
| xtal_tick | input | 1 | External crystal enable pulse |
| ext_fail | input | 1 | External oscillator failure flag |
| lsclk_tick | output | 1 | Selected low-speed tick |
| pin_tick | output | 1 | Gated copy of the tick for the pin |

## Verification
The assertions take for granted that:

- `rc_tick`, `xtal_tick` and `ext_fail` are already synchronous to `clk` and single-bit clean.
- `PRE_DIV` is at least 2, so no two divided pulses can be adjacent.
- Register writes last exactly one cycle.

The stimulus respects these assumptions by changing every input only at the falling edge, by holding each write strobe for a single cycle and by keeping the default pre-divide. Output timing is measured as a count of rising edges between pulses, or as an exact echo of the previous cycle's crystal input. Checks are made only after the source state has had two edges to settle.

// File: rtl/lsclk_pkg.sv
`timescale 1ns/1ps
package lsclk_pkg;
    localparam logic [15:0] CTRL_KEY = 16'h16AA;
    localparam int SEL_BIT   = 0;
    localparam int XEN_BIT   = 4;
    localparam int BYP_BIT   = 15;
    localparam int A_CTRL    = 0;
    localparam int A_PRESC   = 1;
    localparam int A_GATE    = 2;

    typedef enum logic [1:0] {
        ST_INT      = 2'd0,
        ST_EXT      = 2'd1,
        ST_FALLBACK = 2'd2
    } src_state_e;

    typedef struct packed {
        logic bypass;
        logic xtal_en;
        logic sel_ext;
    } ctrl_t;
endpackage

// File: rtl/lsclk_regs.sv
`timescale 1ns/1ps
module lsclk_regs
    import lsclk_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int P_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output ctrl_t             ctrl,
    output logic [P_W-1:0]    presc,
    output logic              gate_en,
    output logic              presc_reload
);
    ctrl_t          ctrl_q;
    logic [P_W-1:0] presc_q;
    logic           gate_q;
    logic           hit_ctrl, hit_presc, hit_gate, key_ok;
    logic           wdata_unused;

    assign hit_ctrl  = reg_we && (reg_addr == ADDR_W'(A_CTRL));
    assign hit_presc = reg_we && (reg_addr == ADDR_W'(A_PRESC));
    assign hit_gate  = reg_we && (reg_addr == ADDR_W'(A_GATE));
    assign key_ok    = (reg_wdata[31:16] == CTRL_KEY);
    assign presc_reload = hit_presc && (reg_wdata[P_W-1:0] != presc_q);
    assign wdata_unused = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            presc_q <= '0;
            gate_q  <= 1'b0;
        end else begin
            if (hit_ctrl && key_ok) begin
                ctrl_q.sel_ext <= reg_wdata[SEL_BIT];
                ctrl_q.xtal_en <= reg_wdata[XEN_BIT];
                ctrl_q.bypass  <= reg_wdata[BYP_BIT];
            end
            if (hit_presc) presc_q <= reg_wdata[P_W-1:0];
            if (hit_gate)  gate_q  <= reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL)) begin
            reg_rdata[SEL_BIT] = ctrl_q.sel_ext;
            reg_rdata[XEN_BIT] = ctrl_q.xtal_en;
            reg_rdata[BYP_BIT] = ctrl_q.bypass;
        end else if (reg_addr == ADDR_W'(A_PRESC)) begin
            reg_rdata[P_W-1:0] = presc_q;
        end else if (reg_addr == ADDR_W'(A_GATE)) begin
            reg_rdata[0] = gate_q;
        end
    end

    assign ctrl    = ctrl_q;
    assign presc   = presc_q;
    assign gate_en = gate_q;

    // R1
    key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(A_CTRL) && reg_wdata[31:16] != CTRL_KEY)
        |=> $stable(ctrl_q));
endmodule

// File: rtl/lsclk_srcsel.sv
`timescale 1ns/1ps
module lsclk_srcsel
    import lsclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ctrl_t      ctrl,
    input  logic       ext_fail,
    output logic       use_ext,
    output src_state_e state
);
    src_state_e state_q, state_d;
    logic       fail_live;

    assign fail_live = ext_fail && !ctrl.bypass;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INT: begin
                if (ctrl.sel_ext) state_d = fail_live ? ST_FALLBACK : ST_EXT;   // go_ext / go_fallback
            end
            ST_EXT: begin
                if (!ctrl.sel_ext) state_d = ST_INT;                           // go_int
                else if (fail_live) state_d = ST_FALLBACK;                      // go_fallback
            end
            ST_FALLBACK: begin
                if (!ctrl.sel_ext) state_d = ST_INT;                           // go_int
                else if (!fail_live) state_d = ST_EXT;                          // recover
            end
            default: state_d = ST_INT;
        endcase
    end

    always_comb begin
        use_ext = 1'b0;
        unique case (state_q)
            ST_EXT:      use_ext = 1'b1;
            ST_INT,
            ST_FALLBACK: use_ext = 1'b0;
            default:     use_ext = 1'b0;
        endcase
    end

    assign state = state_q;

    // R5
    fallback_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FALLBACK) |-> ($past(ext_fail) && $past(ctrl.sel_ext)));
endmodule

// File: rtl/lsclk_divider.sv
`timescale 1ns/1ps
module lsclk_divider #(
    parameter int PRE_DIV = 32,
    parameter int P_W     = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_in,
    input  logic [P_W-1:0] ratio,
    input  logic           reload,
    output logic           tick_out
);
    localparam int PC_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    logic           pre_pulse;
    logic [P_W-1:0] dc_q;

    generate
        if (PRE_DIV > 1) begin : g_pre
            logic [PC_W-1:0] pc_q;
            assign pre_pulse = tick_in && (pc_q == PC_W'(PRE_DIV - 1));
            always_ff @(posedge clk) begin
                if (!rst_n || reload)  pc_q <= '0;
                else if (pre_pulse)    pc_q <= '0;
                else if (tick_in)      pc_q <= pc_q + 1'b1;
            end
        end else begin : g_nopre
            assign pre_pulse = tick_in;
        end
    endgenerate

    assign tick_out = pre_pulse && (dc_q == ratio);

    always_ff @(posedge clk) begin
        if (!rst_n || reload) dc_q <= '0;
        else if (tick_out)    dc_q <= '0;
        else if (pre_pulse)   dc_q <= dc_q + 1'b1;
    end

    // R3
    div_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> tick_in);

    // R3
    div_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out && PRE_DIV > 1) |=> !tick_out);
endmodule

// File: rtl/lsclk_sel.sv
`timescale 1ns/1ps
module lsclk_sel
    import lsclk_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int PRE_DIV = 32,
    parameter int P_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rc_tick,
    input  logic              xtal_tick,
    input  logic              ext_fail,
    output logic              lsclk_tick,
    output logic              pin_tick
);
    ctrl_t          ctrl;
    logic [P_W-1:0] presc;
    logic           gate_en, presc_reload, use_ext, div_tick, tick_q;
    src_state_e     state;

    lsclk_regs #(.ADDR_W(ADDR_W), .P_W(P_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl(ctrl),
        .presc(presc), .gate_en(gate_en), .presc_reload(presc_reload)
    );

    lsclk_srcsel u_sel (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ext_fail(ext_fail),
        .use_ext(use_ext), .state(state)
    );

    lsclk_divider #(.PRE_DIV(PRE_DIV), .P_W(P_W)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_in(rc_tick), .ratio(presc),
        .reload(presc_reload), .tick_out(div_tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= use_ext ? xtal_tick : div_tick;
    end

    assign lsclk_tick = tick_q;
    assign pin_tick   = tick_q & gate_en;

    // R4
    ext_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXT) |=> (lsclk_tick == $past(xtal_tick)));
endmodule

// File: tb/test_lsclk_sel.sv
`timescale 1ns/1ps
module test_lsclk_sel;
    localparam int PRE = 32;
    localparam logic [15:0] KEY = 16'h16AA;
    localparam int NV = 4;
    localparam int VEC [NV][2] = '{'{0, 32}, '{1, 64}, '{5, 192}, '{31, 1024}};

    logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        rc_tick = 1'b0, xtal_tick = 1'b0, ext_fail = 1'b0;
    logic        lsclk_tick, pin_tick;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    lsclk_sel i_lsclk_sel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rc_tick(rc_tick),
        .xtal_tick(xtal_tick), .ext_fail(ext_fail),
        .lsclk_tick(lsclk_tick), .pin_tick(pin_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic measure(output int per);
        int n;
        per = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (lsclk_tick) break;
        end
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); n++;
            if (lsclk_tick) begin per = n; break; end
        end
    endtask

    task automatic echo(input string req, input bit gate_on);
        logic [15:0] pat = 16'b1011_0010_1110_0101;
        logic prev = xtal_tick;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk(lsclk_tick == prev, req, lsclk_tick, prev);
            chk(pin_tick == (gate_on & prev), "R8", pin_tick, gate_on & prev);
            xtal_tick = pat[i];
            prev = pat[i];
        end
        @(negedge clk); xtal_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int per, n;
        // R9 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, d); chk(d == 0, "R9", d, 0);
        rd(2'd1, d); chk(d == 0, "R9", d, 0);
        rd(2'd2, d); chk(d == 0, "R9", d, 0);
        chk(lsclk_tick == 0 && pin_tick == 0, "R9", lsclk_tick, 0);

        // R3 table of prescale values and periods
        rc_tick = 1'b1;
        for (int v = 0; v < NV; v++) begin
            wr(2'd1, 32'(VEC[v][0]));
            measure(per);
            chk(per == VEC[v][1], "R3", per, VEC[v][1]);
        end

        // R7 reload on prescale change (31 -> 2)
        wr(2'd1, 32'd2);
        n = -1;
        for (int i = 1; i < 2000; i++) begin
            @(negedge clk);
            if (lsclk_tick) begin n = i; break; end
        end
        chk(n == PRE * 3, "R7", n, PRE * 3);

        // R1 key check
        rc_tick = 1'b0; xtal_tick = 1'b1;
        wr(2'd0, 32'h0000_0011);
        wr(2'd0, {16'h16AB, 16'h0011});
        rd(2'd0, d); chk(d == 0, "R1", d, 0);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); if (lsclk_tick) n++;
        end
        chk(n == 0, "R1", n, 0);
        xtal_tick = 1'b0;

        // R2 readback layout
        wr(2'd0, {KEY, 16'hFFFF});
        rd(2'd0, d); chk(d == 32'h0000_8011, "R2", d, 32'h8011);
        wr(2'd0, {KEY, 16'h0011});
        rd(2'd0, d); chk(d == 32'h0000_0011, "R2", d, 32'h11);

        // R4 external echo, gate off then on (R8)
        repeat (3) @(negedge clk);
        echo("R4", 1'b0);
        wr(2'd2, 32'd1);
        echo("R4", 1'b1);

        // R5 fall-back to internal path
        ext_fail = 1'b1; rc_tick = 1'b1;
        measure(per);
        chk(per == PRE * 3, "R5", per, PRE * 3);
        rd(2'd0, d); chk(d[0] == 1'b1, "R5", d[0], 1);

        // R6 bypass keeps external clock despite failure
        wr(2'd0, {KEY, 16'h8011});
        rc_tick = 1'b0;
        repeat (3) @(negedge clk);
        echo("R6", 1'b1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule